// File: doc/BRIEF.md
# Miss Status Register File

This block tracks the block misses that a non-blocking cache has sent to the next memory level and still has outstanding. Each miss is keyed by its block address. Every load or store that misses is attached to a small per-entry slot list. A miss to a block that is already outstanding joins the existing entry and sends nothing further to memory. A miss to a new block claims a free entry, and that entry sends one request downstream. When neither an entry nor a slot is available, the cache is told to stall.

Returning sub-blocks are captured into the entry and marked as arrived. Every slot whose sub-block has arrived is answered with its data, one answer per cycle, and the slot is then released. The same path serves an access that joins an entry after its sub-block has already come back. When every sub-block of an entry is present and no slot is still waiting, the entry hands the whole block to the cache in a single write cycle and becomes free again.

Top module: `mshr_file`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_stall`, `mem_req_valid`, `resp_valid` and `wr_valid` are all low.
- R2: A miss whose block address matches no valid entry is accepted without stall and claims the lowest free entry. That entry then raises `mem_req_valid` with `mem_req_addr` equal to the block address, holds it while `mem_req_ready` is low, and drops it after one handshake. Unissued entries are offered lowest index first.
- R3: A miss whose block address matches a valid entry with a free slot is accepted without stall and issues no further memory request. No two valid entries ever hold the same block address.
- R4: A miss that matches no entry while every entry is valid raises `req_stall` in the same cycle and is not recorded.
- R5: A miss that matches an entry whose NUM_SLOT slots are all waiting raises `req_stall` in the same cycle and is not recorded. `req_stall` is never high without `req_valid`.
- R6: A fill (`fill_valid` with `fill_addr` equal to an issued entry's address and `fill_sub` naming the sub-block) stores the data. From the cycle after the fill, every slot waiting on that sub-block receives one `resp_valid` cycle carrying its tag, its store flag and the filled data. Answers come one per cycle, lowest entry first and then lowest slot first, and each slot is released after it is answered.
- R7: A miss that joins an entry whose requested sub-block has already arrived is answered with the stored data in the second cycle after it is accepted.
- R8: Once all NUM_SUB sub-blocks of an entry have arrived and none of its slots is waiting, `wr_valid` pulses for exactly one cycle with `wr_addr` set to the block address and `wr_data` holding sub-block i at bits [i*DATA_W +: DATA_W]. The entry is then free for a new miss.
- R9: A fill whose address matches no issued entry changes no entry: it produces no response and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A cache miss is presented |
| req_addr | input | ADDR_W | Block address of the miss |
| req_sub | input | SUB_W | Sub-block the access needs |
| req_store | input | 1 | Access is a store (1) or a load (0) |
| req_tag | input | TAG_W | Destination register tag or store-buffer index |
| req_stall | output | 1 | Miss cannot be taken this cycle |
| mem_req_valid | output | 1 | Block request to the next level |
| mem_req_addr | output | ADDR_W | Address of that request |
| mem_req_ready | input | 1 | Next level takes the request |
| fill_valid | input | 1 | A sub-block is returning |
| fill_addr | input | ADDR_W | Block address of the returning sub-block |
| fill_sub | input | SUB_W | Index of the returning sub-block |
| fill_data | input | DATA_W | Returning sub-block data |
| resp_valid | output | 1 | A waiting access is answered |
| resp_store | output | 1 | The answered access was a store |
| resp_tag | output | TAG_W | Tag of the answered access |
| resp_data | output | DATA_W | Sub-block data for the answered access |
| wr_valid | output | 1 | Completed block is written to the cache |
| wr_addr | output | ADDR_W | Block address of the write |
| wr_data | output | NUM_SUB*DATA_W | Completed block contents |

## Verification
The bench fills the slots of one entry and then presents a third miss to it. A design that compared against free entries rather than free slots would accept that miss and lose it silently. It occupies every entry and presents an unrelated address, which would overwrite a live miss if the full check were missing. It also holds the downstream handshake off, so a request that is dropped or repeated shows up in the issue log. Two loads wait on the same sub-block, so a design that answered only one waiter per fill would leave the second hung. A late miss arrives for a sub-block that is already present; a design that only forwarded at fill time would never answer it. A stray fill to an unknown address is followed by silence on the response port, which exposes a matcher that ignores the address or the issued flag.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Index width that stays at least one bit for single-element structures.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mshr_pick.sv
// Lowest-index-first one-hot selector.
module mshr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int NUM_ENT  = 4,
  parameter int NUM_SLOT = 2,
  parameter int NUM_SUB  = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 26,
  parameter int TAG_W    = 5,
  localparam int SUB_W   = idx_w(NUM_SUB),
  localparam int BLK_W   = NUM_SUB * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SUB_W-1:0]  req_sub,
  input  logic              req_store,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_stall,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [SUB_W-1:0]  fill_sub,
  input  logic [DATA_W-1:0] fill_data,
  output logic              resp_valid,
  output logic              resp_store,
  output logic [TAG_W-1:0]  resp_tag,
  output logic [DATA_W-1:0] resp_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BLK_W-1:0]  wr_data
);
  localparam int TOT = NUM_ENT * NUM_SLOT;

  // Entry state
  logic [NUM_ENT-1:0] ent_vld, ent_iss;
  logic [ADDR_W-1:0]  ent_addr [NUM_ENT];
  logic [NUM_SUB-1:0] ent_arr  [NUM_ENT];
  logic [BLK_W-1:0]   ent_blk  [NUM_ENT];

  // Slot state, slot k belongs to entry k / NUM_SLOT
  logic [TOT-1:0]     sl_vld, sl_st;
  logic [SUB_W-1:0]   sl_sub [TOT];
  logic [TAG_W-1:0]   sl_tag [TOT];

  logic [NUM_ENT-1:0]  match, fhit, alloc_oh, iss_oh, done, wb_oh, tgt_ent;
  logic [NUM_SLOT-1:0] mrg_free, mrg_oh, tgt_slot;
  logic [TOT-1:0]      rdy, rsp_oh;
  logic                hit, accept;

  always_comb begin
    mrg_free = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      match[e] = ent_vld[e] && (ent_addr[e] == req_addr);
      fhit[e]  = ent_vld[e] && ent_iss[e] && (ent_addr[e] == fill_addr);
      for (int s = 0; s < NUM_SLOT; s++)
        if (match[e] && !sl_vld[e*NUM_SLOT+s]) mrg_free[s] = 1'b1;
    end
    hit = |match;
  end

  mshr_pick #(.N(NUM_SLOT)) u_pick_slot (.req(mrg_free),           .gnt(mrg_oh));
  mshr_pick #(.N(NUM_ENT))  u_pick_ent  (.req(~ent_vld),           .gnt(alloc_oh));
  mshr_pick #(.N(NUM_ENT))  u_pick_iss  (.req(ent_vld & ~ent_iss), .gnt(iss_oh));
  mshr_pick #(.N(TOT))      u_pick_rsp  (.req(rdy),                .gnt(rsp_oh));
  mshr_pick #(.N(NUM_ENT))  u_pick_wb   (.req(done),               .gnt(wb_oh));

  assign req_stall = req_valid && (hit ? !(|mrg_free) : &ent_vld);
  assign accept    = req_valid && !req_stall;
  assign tgt_ent   = hit ? match : alloc_oh;
  assign tgt_slot  = hit ? mrg_oh : NUM_SLOT'(1);

  always_comb begin
    for (int k = 0; k < TOT; k++)
      rdy[k] = sl_vld[k] && ent_arr[k/NUM_SLOT][sl_sub[k]];
    for (int e = 0; e < NUM_ENT; e++)
      done[e] = ent_vld[e] && (&ent_arr[e]) && !(|sl_vld[e*NUM_SLOT +: NUM_SLOT])
                && !(accept && match[e]);
  end

  always_comb begin
    mem_req_valid = |iss_oh;
    mem_req_addr  = '0;
    for (int e = 0; e < NUM_ENT; e++)
      if (iss_oh[e]) mem_req_addr = ent_addr[e];
  end

  // Control state with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld    <= '0;
      ent_iss    <= '0;
      sl_vld     <= '0;
      resp_valid <= 1'b0;
      wr_valid   <= 1'b0;
    end else begin
      resp_valid <= |rdy;
      wr_valid   <= |done;
      for (int k = 0; k < TOT; k++)
        if (rsp_oh[k]) sl_vld[k] <= 1'b0;
      for (int e = 0; e < NUM_ENT; e++) begin
        if (wb_oh[e]) ent_vld[e] <= 1'b0;
        if (mem_req_ready && iss_oh[e]) ent_iss[e] <= 1'b1;
        if (accept && tgt_ent[e]) begin
          if (!hit) begin
            ent_vld[e] <= 1'b1;
            ent_iss[e] <= 1'b0;
          end
          for (int s = 0; s < NUM_SLOT; s++)
            if (tgt_slot[s]) sl_vld[e*NUM_SLOT+s] <= 1'b1;
        end
      end
    end
  end

  // Payload storage without reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < TOT; k++)
      if (rsp_oh[k]) begin
        resp_tag   <= sl_tag[k];
        resp_store <= sl_st[k];
        resp_data  <= ent_blk[k/NUM_SLOT][sl_sub[k]*DATA_W +: DATA_W];
      end
    for (int e = 0; e < NUM_ENT; e++) begin
      if (wb_oh[e]) begin
        wr_addr <= ent_addr[e];
        wr_data <= ent_blk[e];
      end
      if (fill_valid && fhit[e]) begin
        ent_arr[e][fill_sub] <= 1'b1;
        ent_blk[e][fill_sub*DATA_W +: DATA_W] <= fill_data;
      end
      if (accept && tgt_ent[e]) begin
        if (!hit) begin
          ent_addr[e] <= req_addr;
          ent_arr[e]  <= '0;
        end
        for (int s = 0; s < NUM_SLOT; s++)
          if (tgt_slot[s]) begin
            sl_st[e*NUM_SLOT+s]  <= req_store;
            sl_sub[e*NUM_SLOT+s] <= req_sub;
            sl_tag[e*NUM_SLOT+s] <= req_tag;
          end
      end
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NE = 4,
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_stall,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [NE-1:0] ent_vld,
  input logic [AW-1:0] ent_addr [NE]
);
  logic dup, nomatch;

  always_comb begin
    dup     = 1'b0;
    nomatch = 1'b1;
    for (int a = 0; a < NE; a++) begin
      if (ent_vld[a] && ent_addr[a] == req_addr) nomatch = 1'b0;
      for (int b = a + 1; b < NE; b++)
        if (ent_vld[a] && ent_vld[b] && ent_addr[a] == ent_addr[b]) dup = 1'b1;
    end
  end

  p_unique_block_r3: assert property (@(posedge clk) disable iff (rst) !dup);

  p_stall_when_full_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (&ent_vld) && nomatch) |-> req_stall);

  p_stall_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    req_stall |-> req_valid);

  p_single_write_r8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !(wr_valid && wr_addr == $past(wr_addr)));
endmodule

bind mshr_file mshr_file_chk #(.NE(NUM_ENT), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_stall(req_stall), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .ent_vld(ent_vld), .ent_addr(ent_addr)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_store = 1'b0;
  logic [25:0]   req_addr = '0;
  logic [1:0]    req_sub = '0;
  logic [4:0]    req_tag = '0;
  logic          req_stall;
  logic          mem_req_valid, mem_req_ready = 1'b0;
  logic [25:0]   mem_req_addr;
  logic          fill_valid = 1'b0;
  logic [25:0]   fill_addr = '0;
  logic [1:0]    fill_sub = '0;
  logic [31:0]   fill_data = '0;
  logic          resp_valid, resp_store;
  logic [4:0]    resp_tag;
  logic [31:0]   resp_data;
  logic          wr_valid;
  logic [25:0]   wr_addr;
  logic [127:0]  wr_data;

  always #4 clk = ~clk;

  mshr_file u_mshr_file (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_sub(req_sub), .req_store(req_store), .req_tag(req_tag),
    .req_stall(req_stall), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_sub(fill_sub),
    .fill_data(fill_data), .resp_valid(resp_valid), .resp_store(resp_store),
    .resp_tag(resp_tag), .resp_data(resp_data), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Stimulus table: allocation phase with the downstream port held off
  localparam logic [25:0] T_ADDR [8] = '{26'h100, 26'h100, 26'h100, 26'h200,
                                         26'h300, 26'h400, 26'h500, 26'h200};
  localparam logic [1:0]  T_SUB  [8] = '{2'd1, 2'd2, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd1};
  localparam logic [4:0]  T_TAG  [8] = '{5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8};
  localparam logic        T_ST   [8] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic        T_STL  [8] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam string       T_REQ  [8] = '{"R2", "R3", "R5", "R2", "R2", "R2", "R4", "R3"};

  int checks = 0, errors = 0, cyc = 0;

  // Output logs, sampled 1 ns before each rising edge
  logic [4:0]  rtag [64];
  logic [31:0] rdat [64];
  logic        rst_l [64];
  logic [25:0] ilog [16];
  logic [25:0] wlog_a [8];
  logic [127:0] wlog_d [8];
  int nr = 0, ni = 0, nw = 0;

  always @(negedge clk) begin
    #3;
    if (!rst) begin
      if (resp_valid && nr < 64) begin
        rtag[nr] = resp_tag; rdat[nr] = resp_data; rst_l[nr] = resp_store; nr++;
      end
      if (mem_req_valid && mem_req_ready && ni < 16) begin
        ilog[ni] = mem_req_addr; ni++;
      end
      if (wr_valid && nw < 8) begin
        wlog_a[nw] = wr_addr; wlog_d[nw] = wr_data; nw++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [25:0] a, input logic [1:0] s, input logic [4:0] t,
                        input logic st, output logic stl);
    @(negedge clk);
    fill_valid = 1'b0;
    req_valid = 1'b1; req_addr = a; req_sub = s; req_tag = t; req_store = st;
    #1 stl = req_stall;
  endtask

  task automatic do_fill(input logic [25:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b1; fill_addr = a; fill_sub = s; fill_data = d;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0;
    end
  endtask

  initial begin
    logic stl;
    int nr0, nw0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 stall in reset", {127'd0, req_stall}, 128'd0);
    chk("R1 mem_req in reset", {127'd0, mem_req_valid}, 128'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 resp after reset", {127'd0, resp_valid}, 128'd0);
    chk("R1 wr after reset", {127'd0, wr_valid}, 128'd0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      do_req(T_ADDR[i], T_SUB[i], T_TAG[i], T_ST[i], stl);
      chk(T_REQ[i], {127'd0, stl}, {127'd0, T_STL[i]});
    end
    idle(2);
    #1;
    chk("R2 request held while not ready", {101'd0, mem_req_valid, mem_req_addr},
        {101'd0, 1'b1, 26'h100});
    chk("R2 no handshake while not ready", 128'(ni), 128'd0);

    @(negedge clk); mem_req_ready = 1'b1;
    idle(6);
    chk("R3 one request per block", 128'(ni), 128'd4);
    chk("R2 issue order 0", {102'd0, ilog[0]}, {102'd0, 26'h100});
    chk("R2 issue order 1", {102'd0, ilog[1]}, {102'd0, 26'h200});
    chk("R2 issue order 3", {102'd0, ilog[3]}, {102'd0, 26'h400});
    chk("R6 nothing answered before fill", 128'(nr), 128'd0);

    // Fill block 0x100 in scrambled sub-block order
    do_fill(26'h100, 2'd1, 32'hA000_0001);
    do_fill(26'h100, 2'd2, 32'hA000_0002);
    do_fill(26'h100, 2'd0, 32'hA000_0000);
    do_fill(26'h100, 2'd3, 32'hA000_0003);
    idle(6);
    chk("R6 two answers for block 0x100", 128'(nr), 128'd2);
    chk("R6 load tag", {123'd0, rtag[0]}, {123'd0, 5'd1});
    chk("R6 load data", {96'd0, rdat[0]}, {96'd0, 32'hA000_0001});
    chk("R6 store tag and flag", {122'd0, rst_l[1], rtag[1]}, {122'd0, 1'b1, 5'd2});
    chk("R6 store data", {96'd0, rdat[1]}, {96'd0, 32'hA000_0002});
    chk("R8 one block write", 128'(nw), 128'd1);
    chk("R8 write address", {102'd0, wlog_a[0]}, {102'd0, 26'h100});
    chk("R8 write data layout", wlog_d[0],
        {32'hA000_0003, 32'hA000_0002, 32'hA000_0001, 32'hA000_0000});

    // Freed entry takes a new miss that stalled earlier
    do_req(26'h500, 2'd0, 5'd7, 1'b0, stl);
    chk("R8 freed entry reusable", {127'd0, stl}, 128'd0);
    idle(3);
    chk("R2 new block issued", {102'd0, ilog[4]}, {102'd0, 26'h500});
    chk("R2 issue count", 128'(ni), 128'd5);

    // Two loads waiting on one sub-block
    nr0 = nr;
    do_req(26'h300, 2'd3, 5'd10, 1'b0, stl);
    chk("R3 merge accepted", {127'd0, stl}, 128'd0);
    do_fill(26'h300, 2'd3, 32'hC0DE_0303);
    idle(4);
    chk("R6 both waiters answered", 128'(nr - nr0), 128'd2);
    chk("R6 first waiter", {123'd0, rtag[nr0]}, {123'd0, 5'd5});
    chk("R6 second waiter", {123'd0, rtag[nr0+1]}, {123'd0, 5'd10});
    chk("R6 second waiter data", {96'd0, rdat[nr0+1]}, {96'd0, 32'hC0DE_0303});

    // Late access to an arrived sub-block
    nr0 = nr;
    do_fill(26'h200, 2'd0, 32'hBEEF_0200);
    idle(3);
    chk("R6 fill answer for 0x200", {123'd0, rtag[nr0]}, {123'd0, 5'd4});
    do_req(26'h200, 2'd0, 5'd9, 1'b0, stl);
    chk("R7 late access accepted", {127'd0, stl}, 128'd0);
    idle(3);
    chk("R7 late access answered", 128'(nr - nr0), 128'd2);
    chk("R7 late access tag", {123'd0, rtag[nr0+1]}, {123'd0, 5'd9});
    chk("R7 late access data", {96'd0, rdat[nr0+1]}, {96'd0, 32'hBEEF_0200});
    chk("R3 no request for late access", 128'(ni), 128'd5);

    // Stray fill, then the real one
    nr0 = nr; nw0 = nw;
    do_fill(26'h777, 2'd1, 32'hDEAD_0777);
    idle(4);
    chk("R9 stray fill no answer", 128'(nr - nr0), 128'd0);
    chk("R9 stray fill no write", 128'(nw - nw0), 128'd0);
    do_fill(26'h200, 2'd1, 32'hBEEF_0201);
    idle(3);
    chk("R6 waiter on sub1 answered", {123'd0, rtag[nr0]}, {123'd0, 5'd8});
    chk("R6 waiter on sub1 data", {96'd0, rdat[nr0]}, {96'd0, 32'hBEEF_0201});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule